// File: doc/BRIEF.md
# Dual-Width Prefetch Refill Unit

This block holds the program counter and a two-entry instruction prefetch queue for a small 32-bit core. The core runs in one of two instruction states: word state, with 32-bit opcodes, and halfword state, with 16-bit opcodes. A redirect can come from a branch, a register-indirect branch, a PC write, a state switch or an exception entry. On a redirect the unit aligns the new PC to the width of the new state. It then refills both queue entries straight away from memory at that width. It does not just mark the old entries empty.

After a refill the unit raises a refilled flag. The first step after the refill moves the PC forward by two opcode widths. Every later step moves it by one width and fetches one new opcode into the back entry. The unit stops presenting an opcode from the moment of a redirect until both entries hold fresh data. A new redirect that arrives during a refill drops the fetch in flight and starts again from the newest target. Memory is reached through a request port with a valid/ready handshake and a response port that returns data in order.

Top module: `pfq_refill`

## Requirements
- R1: After reset the PC is 0x0800_0000, the unit is in word state, the refilled flag is 1, and no opcode is presented until the refill from 0x0800_0000 completes.
- R2: A direct redirect (kind 0) takes its state from the redirect state input (1 = halfword). Entering halfword state clears PC bit 0. Entering word state clears PC bits 1:0.
- R3: On a register-indirect redirect (kind 1), bit 0 of the target selects the new state (1 = halfword), and the target is aligned for that state as in R2.
- R4: A software-interrupt redirect (kind 2) sets the PC to 0x08, and an interrupt redirect (kind 3) sets it to 0x18. Both always enter word state.
- R5: A refill fetches entry 0 from the PC and entry 1 from PC+4 in word state, or from PC+2 in halfword state. Every request is aligned and its width flag equals the state.
- R6: From the cycle after a redirect, opcode-valid stays low until both entries have data. The presented opcode is entry 0. In halfword state its upper 16 bits are zero.
- R7: The first accepted step after a refill adds two widths to the PC and clears the refilled flag. Every other accepted step adds one width and refetches the back entry from the new PC.
- R8: A step while opcode-valid is low leaves the PC unchanged. A step in the same cycle as a redirect is dropped, and the redirect takes effect.
- R9: A redirect during a refill discards the response of any fetch still in flight. The opcodes presented afterwards come only from the newest target.
- R10: A request that is not accepted stays asserted, with the same address and width, into the next cycle unless a redirect intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect request this cycle |
| redir_kind | input | 2 | 0 direct, 1 register-indirect, 2 software interrupt, 3 interrupt |
| redir_addr | input | 32 | Target address (or source register value for kind 1) |
| redir_half | input | 1 | New state for kind 0 (1 = halfword) |
| step | input | 1 | Consume the presented opcode |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | 32 | Fetch address |
| mem_req_half | output | 1 | Fetch width, 1 = 16-bit |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Fetch data returned |
| mem_rsp_data | input | 32 | Fetch data; a halfword sits in bits 15:0 |
| op_valid | output | 1 | Both entries hold data |
| op_data | output | 32 | Current opcode (entry 0) |
| pc_out | output | 32 | Program counter |
| half_mode | output | 1 | Current state, 1 = halfword |
| refilled | output | 1 | Queue was refilled since the last step |

## Verification
The bench goes after the double PC advance on the first step after a refill. A design that advanced only once would show the wrong PC and then present the wrong back-entry opcode. It redirects while a fetch with a long fixed latency is still in flight. A design that kept the late response would present an opcode from the cancelled target. It uses misaligned targets in both states, and indirect targets whose bit 0 flips the state, to catch wrong alignment masks and a wrong refill width. Steps that arrive while the queue is empty, or together with a redirect, must leave the PC untouched or let the redirect win.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    parameter int XLEN   = 32;
    parameter int HALF_W = 16;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        RD_DIRECT   = 2'd0,
        RD_INDIRECT = 2'd1,
        RD_SWI      = 2'd2,
        RD_IRQ      = 2'd3
    } redir_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_state_e;

    typedef struct packed {
        word_t addr;
        logic  half;
    } fetch_tgt_t;

    function automatic word_t align_pc(word_t a, logic half);
        return half ? {a[XLEN-1:1], 1'b0} : {a[XLEN-1:2], 2'b00};
    endfunction

    function automatic word_t step_size(logic half);
        return half ? word_t'(2) : word_t'(4);
    endfunction

    function automatic word_t fit_opcode(word_t d, logic half);
        return half ? {{(XLEN-HALF_W){1'b0}}, d[HALF_W-1:0]} : d;
    endfunction
endpackage

// File: rtl/pfq_redirect_decode.sv
module pfq_redirect_decode
    import pfq_pkg::*;
#(
    parameter word_t SWI_VEC = 32'h0000_0008,
    parameter word_t IRQ_VEC = 32'h0000_0018
) (
    input  redir_kind_e kind,
    input  word_t       addr,
    input  logic        half_req,
    output fetch_tgt_t  tgt
);
    always_comb begin
        unique case (kind)
            RD_DIRECT: begin
                tgt.half = half_req;
                tgt.addr = align_pc(addr, half_req);
            end
            RD_INDIRECT: begin
                tgt.half = addr[0];
                tgt.addr = align_pc(addr, addr[0]);
            end
            RD_SWI: begin
                tgt.half = 1'b0;
                tgt.addr = align_pc(SWI_VEC, 1'b0);
            end
            default: begin
                tgt.half = 1'b0;
                tgt.addr = align_pc(IRQ_VEC, 1'b0);
            end
        endcase
    end
endmodule

// File: rtl/pfq_fetch_seq.sv
module pfq_fetch_seq
    import pfq_pkg::*;
#(
    parameter word_t RESET_PC = 32'h0800_0000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  fetch_tgt_t restart_tgt,
    input  logic       advance,
    input  word_t      advance_addr,
    input  logic       cur_half,
    output logic       mem_req_valid,
    output word_t      mem_req_addr,
    output logic       mem_req_half,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  word_t      mem_rsp_data,
    output logic       wr_en,
    output logic       wr_slot,
    output word_t      wr_data
);
    fetch_state_e st_q;
    word_t        fa_q;
    logic         fhalf_q;
    logic         fslot_q;
    logic         stale_q;
    logic         fire;

    assign mem_req_valid = (st_q == FS_ISSUE) && !stale_q;
    assign mem_req_addr  = fa_q;
    assign mem_req_half  = fhalf_q;
    assign fire          = mem_req_valid && mem_req_ready;

    assign wr_en   = (st_q == FS_WAIT) && mem_rsp_valid && !restart;
    assign wr_slot = fslot_q;
    assign wr_data = fit_opcode(mem_rsp_data, fhalf_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FS_ISSUE;
            fa_q    <= align_pc(RESET_PC, 1'b0);
            fhalf_q <= 1'b0;
            fslot_q <= 1'b0;
            stale_q <= 1'b0;
        end else if (restart) begin
            st_q    <= FS_ISSUE;
            fa_q    <= restart_tgt.addr;
            fhalf_q <= restart_tgt.half;
            fslot_q <= 1'b0;
            stale_q <= (stale_q && !mem_rsp_valid)
                    || ((st_q == FS_WAIT) && !mem_rsp_valid)
                    || fire;
        end else if (advance) begin
            st_q    <= FS_ISSUE;
            fa_q    <= advance_addr;
            fhalf_q <= cur_half;
            fslot_q <= 1'b1;
        end else begin
            unique case (st_q)
                FS_ISSUE: begin
                    if (stale_q && mem_rsp_valid) stale_q <= 1'b0;
                    if (fire) st_q <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!fslot_q) begin
                            fslot_q <= 1'b1;
                            fa_q    <= fa_q + step_size(fhalf_q);
                            st_q    <= FS_ISSUE;
                        end else begin
                            st_q <= FS_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: a fetch still in flight at a redirect holds back the next request
    assert_cancel_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (restart && (st_q == FS_WAIT) && !mem_rsp_valid) |=> !mem_req_valid);

    // R5: requests are aligned to their own width
    assert_req_align_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_half ? !mem_req_addr[0] : (mem_req_addr[1:0] == 2'b00)));
endmodule

// File: rtl/pfq_refill.sv
module pfq_refill
    import pfq_pkg::*;
#(
    parameter word_t RESET_PC = 32'h0800_0000,
    parameter word_t SWI_VEC  = 32'h0000_0008,
    parameter word_t IRQ_VEC  = 32'h0000_0018
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       redir_valid,
    input  logic [1:0]                 redir_kind,
    input  logic [pfq_pkg::XLEN-1:0]   redir_addr,
    input  logic                       redir_half,
    input  logic                       step,
    output logic                       mem_req_valid,
    output logic [pfq_pkg::XLEN-1:0]   mem_req_addr,
    output logic                       mem_req_half,
    input  logic                       mem_req_ready,
    input  logic                       mem_rsp_valid,
    input  logic [pfq_pkg::XLEN-1:0]   mem_rsp_data,
    output logic                       op_valid,
    output logic [pfq_pkg::XLEN-1:0]   op_data,
    output logic [pfq_pkg::XLEN-1:0]   pc_out,
    output logic                       half_mode,
    output logic                       refilled
);
    localparam int NSLOT = 2;

    fetch_tgt_t  tgt;
    word_t       pc_q;
    logic        half_q;
    logic        refl_q;
    word_t       slot_q [NSLOT];
    logic [NSLOT-1:0] vld_q;
    word_t       inc;
    word_t       next_pc;
    logic        step_go;
    logic        wr_en;
    logic        wr_slot;
    word_t       wr_data;

    pfq_redirect_decode #(.SWI_VEC(SWI_VEC), .IRQ_VEC(IRQ_VEC)) dec_i (
        .kind     (redir_kind_e'(redir_kind)),
        .addr     (redir_addr),
        .half_req (redir_half),
        .tgt      (tgt)
    );

    assign op_valid = &vld_q;
    assign op_data  = slot_q[0];
    assign pc_out   = pc_q;
    assign half_mode = half_q;
    assign refilled = refl_q;
    assign step_go  = step && op_valid && !redir_valid;
    assign inc      = step_size(half_q);
    assign next_pc  = pc_q + (refl_q ? (inc << 1) : inc);

    pfq_fetch_seq #(.RESET_PC(RESET_PC)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .restart      (redir_valid),
        .restart_tgt  (tgt),
        .advance      (step_go),
        .advance_addr (next_pc),
        .cur_half     (half_q),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_half (mem_req_half),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .wr_en        (wr_en),
        .wr_slot      (wr_slot),
        .wr_data      (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= align_pc(RESET_PC, 1'b0);
            half_q <= 1'b0;
            refl_q <= 1'b1;
            vld_q  <= '0;
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else if (redir_valid) begin
            pc_q   <= tgt.addr;
            half_q <= tgt.half;
            refl_q <= 1'b1;
            vld_q  <= '0;
        end else begin
            if (step_go) begin
                pc_q      <= next_pc;
                refl_q    <= 1'b0;
                slot_q[0] <= slot_q[1];
                vld_q     <= 2'b01;
            end
            if (wr_en) begin
                slot_q[wr_slot] <= wr_data;
                vld_q[wr_slot]  <= 1'b1;
            end
        end
    end

    // R6: a redirect empties the queue
    assert_redir_blank_R6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !op_valid);

    // R7: first step after a refill moves two widths
    assert_double_step_R7: assert property (@(posedge clk) disable iff (rst)
        (step_go && refl_q) |=> (pc_q == $past(pc_q) + ($past(inc) << 1)) && !refl_q);

    // R8: a step with no opcode present leaves the PC alone
    assert_step_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !op_valid && !redir_valid) |=> $stable(pc_q));

    // R4: software-interrupt entry lands at its vector in word state
    assert_swi_vector_R4: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && redir_kind == 2'd2) |=> (pc_q == SWI_VEC) && !half_q);

    // R10: a waiting request is held
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready && !redir_valid)
            |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_half));
endmodule

// File: tb/pfq_refill_tb_top.sv
module pfq_refill_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redir_valid = 1'b0;
    logic [1:0]  redir_kind = 2'd0;
    logic [31:0] redir_addr = '0;
    logic        redir_half = 1'b0;
    logic        step = 1'b0;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_req_valid, mem_req_half, op_valid, half_mode, refilled;
    logic [31:0] mem_req_addr, op_data, pc_out;

    pfq_refill dut_i (
        .clk(clk), .rst(rst),
        .redir_valid(redir_valid), .redir_kind(redir_kind),
        .redir_addr(redir_addr), .redir_half(redir_half),
        .step(step),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_half(mem_req_half), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .op_valid(op_valid), .op_data(op_data), .pc_out(pc_out),
        .half_mode(half_mode), .refilled(refilled)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_val(input logic [31:0] a, input logic h);
        return h ? {16'hDEAD, a[15:0] ^ 16'h5A5A} : {a[15:0] ^ 16'hC3C3, a[15:0] ^ 16'h1111};
    endfunction

    function automatic logic [31:0] exp_op(input logic [31:0] a, input logic h);
        return h ? {16'h0000, a[15:0] ^ 16'h5A5A} : mem_val(a, 1'b0);
    endfunction

    // memory model, active a quarter period after the rising edge
    int          lat_fix = -1;
    bit          ready_force = 0;
    bit          mem_pend = 0;
    bit          saw_fire = 0;
    bit          prev_wait = 0;
    int          lat_cnt = 0;
    logic [31:0] p_addr = '0, f_addr = '0, w_addr = '0;
    logic        p_half = 0, f_half = 0, w_half = 0;

    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst) begin
                mem_rsp_valid = 0; mem_req_ready = 0;
                mem_pend = 0; saw_fire = 0; prev_wait = 0;
            end else begin
                if (prev_wait && !redir_valid)
                    check(mem_req_valid && mem_req_addr == w_addr && mem_req_half == w_half,
                          "R10 request held", mem_req_addr, w_addr);
                mem_rsp_valid = 0;
                if (saw_fire) begin
                    mem_pend = 1;
                    p_addr = f_addr; p_half = f_half;
                    lat_cnt = (lat_fix >= 0) ? lat_fix : int'($urandom % 3);
                end
                if (mem_pend) begin
                    if (lat_cnt == 0) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data = mem_val(p_addr, p_half);
                        mem_pend = 0;
                    end else lat_cnt--;
                end
                mem_req_ready = ready_force ? 1'b1 : (($urandom % 4) != 0);
                saw_fire = mem_req_valid && mem_req_ready;
                f_addr = mem_req_addr; f_half = mem_req_half;
                prev_wait = mem_req_valid && !mem_req_ready;
                w_addr = mem_req_addr; w_half = mem_req_half;
            end
        end
    end

    // reference model
    logic [31:0] m_pc = 32'h0800_0000;
    logic        m_half = 0;
    logic        m_refl = 1;

    function automatic logic [31:0] m_inc();
        return m_half ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] m_slot0();
        return m_refl ? m_pc : m_pc - m_inc();
    endfunction

    task automatic wait_valid(input string tag);
        int n = 0;
        while (!op_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(op_valid, {tag, " refill completes"}, {31'd0, op_valid}, 32'd1);
    endtask

    task automatic do_redirect(input logic [1:0] k, input logic [31:0] a, input logic h,
                               input bit with_step, input string tag);
        @(negedge clk);
        redir_valid = 1; redir_kind = k; redir_addr = a; redir_half = h; step = with_step;
        case (k)
            2'd0: begin m_half = h;    m_pc = h ? {a[31:1], 1'b0} : {a[31:2], 2'b00}; end
            2'd1: begin m_half = a[0]; m_pc = a[0] ? {a[31:1], 1'b0} : {a[31:2], 2'b00}; end
            2'd2: begin m_half = 0;    m_pc = 32'h0000_0008; end
            default: begin m_half = 0; m_pc = 32'h0000_0018; end
        endcase
        m_refl = 1;
        @(negedge clk);
        redir_valid = 0; step = 0;
        check(pc_out == m_pc, {tag, " target pc"}, pc_out, m_pc);
        check(half_mode == m_half, {tag, " state"}, {31'd0, half_mode}, {31'd0, m_half});
        check(refilled && !op_valid, "R6 queue emptied", {30'd0, refilled, op_valid}, 32'd2);
    endtask

    task automatic do_step(input string tag);
        logic [31:0] s0;
        wait_valid(tag);
        s0 = m_slot0();
        check(op_data == exp_op(s0, m_half), {tag, " opcode (R5 R6)"}, op_data, exp_op(s0, m_half));
        step = 1;
        @(negedge clk);
        step = 0;
        m_pc = m_pc + (m_refl ? (m_inc() << 1) : m_inc());
        m_refl = 0;
        check(pc_out == m_pc, "R7 pc advance", pc_out, m_pc);
        check(!refilled, "R7 refilled cleared", {31'd0, refilled}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(pc_out == 32'h0800_0000, "R1 reset pc", pc_out, 32'h0800_0000);
        check(!half_mode && refilled && !op_valid, "R1 reset flags",
              {29'd0, half_mode, refilled, op_valid}, 32'd2);
        do_step("R1");
        do_step("R7");
        do_step("R7");

        // R2 alignment in both states
        do_redirect(2'd0, 32'h0000_1237, 1'b1, 0, "R2 half");
        do_step("R2"); do_step("R2"); do_step("R2");
        do_redirect(2'd0, 32'h0000_2343, 1'b0, 0, "R2 word");
        do_step("R2"); do_step("R2");

        // R3 indirect picks state from bit 0
        do_redirect(2'd1, 32'h0000_4563, 1'b0, 0, "R3 to half");
        do_step("R3"); do_step("R3");
        do_redirect(2'd1, 32'h0000_5676, 1'b1, 0, "R3 to word");
        do_step("R3"); do_step("R3");

        // R4 exception vectors from halfword state
        do_redirect(2'd0, 32'h0000_0100, 1'b1, 0, "R2");
        do_redirect(2'd2, 32'h0000_0101, 1'b1, 0, "R4 swi");
        do_step("R4"); do_step("R4");
        do_redirect(2'd0, 32'h0000_0200, 1'b1, 0, "R2");
        do_redirect(2'd3, 32'h0000_0203, 1'b1, 0, "R4 irq");
        do_step("R4"); do_step("R4");

        // R8 step on empty queue
        do_redirect(2'd0, 32'h0000_3000, 1'b0, 0, "R8 setup");
        step = 1;
        @(negedge clk);
        step = 0;
        check(pc_out == m_pc && refilled, "R8 step ignored", pc_out, m_pc);
        do_step("R8");
        // R8 step together with redirect
        wait_valid("R8");
        do_redirect(2'd0, 32'h0000_3802, 1'b1, 1, "R8 redirect wins");
        do_step("R8");

        // R9 cancel with fetch in flight
        ready_force = 1; lat_fix = 2;
        do_redirect(2'd0, 32'h0000_7000, 1'b0, 0, "R9 first");
        while (!mem_pend) @(negedge clk);
        do_redirect(2'd0, 32'h0000_9A02, 1'b1, 0, "R9 second");
        do_step("R9"); do_step("R9"); do_step("R9");
        // back-to-back redirects
        do_redirect(2'd1, 32'h0000_AB01, 1'b0, 0, "R9 b2b a");
        do_redirect(2'd0, 32'h0000_CD04, 1'b0, 0, "R9 b2b b");
        do_step("R9"); do_step("R9");
        ready_force = 0; lat_fix = -1;

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 5) do_step("R7 rnd");
            else begin
                logic [1:0]  k;
                logic [31:0] a;
                k = 2'($urandom % 4);
                a = $urandom & 32'h000F_FFFF;
                do_redirect(k, a, 1'($urandom % 2), 0, "R2 R3 R4 rnd");
            end
        end
        do_step("R7 final");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule